// File: doc/BRIEF.md
# IQ Sample Packer

This block sits on the receive side of a two-channel converter. It takes four parallel 16-bit sample streams and gathers the samples of the streams that are switched on into 64-bit words for a DMA write path. The streams are channel 0 I and Q, and channel 1 I and Q. Each converter sample is 12 bits wide and travels in a 16-bit lane. The lane is passed through unchanged. Each stream has its own enable and its own valid.

The set of enabled streams selects the packing ratio while the block runs. With one stream enabled, four samples make one word. With two streams enabled, two paired samples make one word. With all four enabled, every input beat makes one word. When the enable set changes, any part-built word is dropped, so a word never mixes two configurations.

The output is a 64-bit word with a single-cycle valid strobe. There is no ready signal and no back-pressure in either direction. The consumer must take every word in the cycle it is offered. The source must present a beat only when it has data.

Top module: `iqp_packer`

## Requirements
- R1: While reset is asserted, and at the first clock after it is released, `word_vld` is 0 and `word_data` is zero.
- R2: A beat is taken only in a cycle where every enabled stream has its valid bit high. A cycle in which any enabled stream is not valid leaves the packing position unchanged and produces no word.
- R3: With exactly one stream enabled, four beats form one word. The earliest sample goes in bits [15:0] and the fourth in bits [63:48]. A word pulse is never followed by another pulse in the next cycle while one stream is enabled.
- R4: With exactly two streams enabled, two beats form one word. Each beat fills two lanes, with the lower-numbered stream in the lower lane. The first beat fills bits [31:0] and the second fills bits [63:32].
- R5: With all four streams enabled, each beat forms a word in the next cycle. Stream 0 (channel 0 I) goes in bits [15:0], stream 1 (channel 0 Q) in [31:16], stream 2 (channel 1 I) in [47:32] and stream 3 (channel 1 Q) in [63:48].
- R6: The output is registered. `word_vld` is high for exactly the cycle after each completing beat and low otherwise. `word_data` keeps its value in every cycle where `word_vld` is low.
- R7: A cycle whose enable set differs from the previous cycle's drops any partial word. A beat in that cycle starts the new word at lane 0.
- R8: An enable set of zero or three streams is unsupported. It takes no beats and produces no word.
- R9: The valid bit and the data of a disabled stream have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_data | input | 64 | Four 16-bit lanes; stream s is in bits [16s+15:16s] |
| smp_en | input | 4 | Per-stream enable, bit s for stream s |
| smp_vld | input | 4 | Per-stream valid, bit s for stream s |
| word_data | output | 64 | Packed output word |
| word_vld | output | 1 | One-cycle strobe marking a new word; there is no ready |

## Verification
The bound checker checks the following on every cycle:
- a word appears only after an accepted beat;
- unsupported enable sets stay silent;
- the full four-stream case yields the exact input beat one cycle later;
- the single-stream case never strobes twice in a row;
- the output word holds between strobes.

Some behaviours depend on a history of several beats, so only the directed scenarios can show them:
- lane ordering across the four beats of single-stream packing and the two beats of pair packing;
- dropping a half-built word on an enable change;
- stalls from partial valid;
- immunity to valid and data on disabled streams.

// File: rtl/iqp_pkg.sv
package iqp_pkg;
  localparam int STREAMS = 4;
  localparam int POS_W   = $clog2(STREAMS);
  localparam int CNT_W   = $clog2(STREAMS) + 1;

  typedef enum logic [1:0] {PM_OFF, PM_X1, PM_X2, PM_X4} pack_mode_e;

  function automatic pack_mode_e mode_of(input logic [STREAMS-1:0] en);
    int n;
    n = 0;
    for (int s = 0; s < STREAMS; s++) n += int'(en[s]);
    case (n)
      1:       return PM_X1;
      2:       return PM_X2;
      STREAMS: return PM_X4;
      default: return PM_OFF;
    endcase
  endfunction
endpackage

// File: rtl/iqp_mode_decode.sv
module iqp_mode_decode
  import iqp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STREAMS-1:0] en,
  input  logic [STREAMS-1:0] vld,
  output logic               beat,
  output logic               restart,
  output logic [CNT_W-1:0]   n_lanes,
  output logic [POS_W-1:0]   last_pos
);
  logic [STREAMS-1:0] en_q;
  pack_mode_e         mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en;
  end

  always_comb begin
    mode    = mode_of(en);
    restart = (en != en_q);
    case (mode)
      PM_X1: begin n_lanes = CNT_W'(1);       last_pos = POS_W'(STREAMS - 1);     end
      PM_X2: begin n_lanes = CNT_W'(2);       last_pos = POS_W'(STREAMS / 2 - 1); end
      PM_X4: begin n_lanes = CNT_W'(STREAMS); last_pos = '0;                      end
      default: begin n_lanes = '0;            last_pos = '0;                      end
    endcase
    beat = (mode != PM_OFF) && ((vld & en) == en);
  end
endmodule

// File: rtl/iqp_lane_compact.sv
module iqp_lane_compact
  import iqp_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic [STREAMS*SAMPLE_W-1:0] data,
  input  logic [STREAMS-1:0]          en,
  output logic [STREAMS*SAMPLE_W-1:0] compact
);
  always_comb begin
    int k;
    k       = 0;
    compact = '0;
    for (int s = 0; s < STREAMS; s++) begin
      if (en[s]) begin
        compact[k*SAMPLE_W +: SAMPLE_W] = data[s*SAMPLE_W +: SAMPLE_W];
        k++;
      end
    end
  end
endmodule

// File: rtl/iqp_word_builder.sv
module iqp_word_builder
  import iqp_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        beat,
  input  logic                        restart,
  input  logic [CNT_W-1:0]            n_lanes,
  input  logic [POS_W-1:0]            last_pos,
  input  logic [STREAMS*SAMPLE_W-1:0] compact,
  output logic [STREAMS*SAMPLE_W-1:0] word_data,
  output logic                        word_vld
);
  localparam int WORD_W = STREAMS * SAMPLE_W;

  logic [POS_W-1:0]    pos;
  logic [POS_W-1:0]    eff_pos;
  logic [WORD_W-1:0]   acc;
  logic [WORD_W-1:0]   asm_word;
  logic [SAMPLE_W-1:0] cl [STREAMS];
  int                  base;

  assign eff_pos = restart ? '0 : pos;
  assign base    = int'(eff_pos) * int'(n_lanes);

  for (genvar j = 0; j < STREAMS; j++) begin : g_lane
    assign cl[j] = compact[j*SAMPLE_W +: SAMPLE_W];

    always_comb begin
      logic [POS_W-1:0] sel;
      sel = POS_W'(j - base);
      if (j >= base && j < base + int'(n_lanes))
        asm_word[j*SAMPLE_W +: SAMPLE_W] = cl[sel];
      else if (eff_pos != '0)
        asm_word[j*SAMPLE_W +: SAMPLE_W] = acc[j*SAMPLE_W +: SAMPLE_W];
      else
        asm_word[j*SAMPLE_W +: SAMPLE_W] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos       <= '0;
      acc       <= '0;
      word_data <= '0;
      word_vld  <= 1'b0;
    end else begin
      word_vld <= 1'b0;
      if (beat) begin
        if (eff_pos == last_pos) begin
          word_data <= asm_word;
          word_vld  <= 1'b1;
          pos       <= '0;
        end else begin
          acc <= asm_word;
          pos <= eff_pos + 1'b1;
        end
      end else if (restart) begin
        pos <= '0;
      end
    end
  end
endmodule

// File: rtl/iqp_packer.sv
module iqp_packer
  import iqp_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [STREAMS*SAMPLE_W-1:0] smp_data,
  input  logic [STREAMS-1:0]          smp_en,
  input  logic [STREAMS-1:0]          smp_vld,
  output logic [STREAMS*SAMPLE_W-1:0] word_data,
  output logic                        word_vld
);
  logic                        beat;
  logic                        restart;
  logic [CNT_W-1:0]            n_lanes;
  logic [POS_W-1:0]            last_pos;
  logic [STREAMS*SAMPLE_W-1:0] compact;

  iqp_mode_decode u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (smp_en),
    .vld      (smp_vld),
    .beat     (beat),
    .restart  (restart),
    .n_lanes  (n_lanes),
    .last_pos (last_pos)
  );

  iqp_lane_compact #(.SAMPLE_W(SAMPLE_W)) u_compact (
    .data    (smp_data),
    .en      (smp_en),
    .compact (compact)
  );

  iqp_word_builder #(.SAMPLE_W(SAMPLE_W)) u_build (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat      (beat),
    .restart   (restart),
    .n_lanes   (n_lanes),
    .last_pos  (last_pos),
    .compact   (compact),
    .word_data (word_data),
    .word_vld  (word_vld)
  );
endmodule

// File: rtl/iqp_packer_chk.sv
module iqp_packer_chk
  import iqp_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [STREAMS*SAMPLE_W-1:0] smp_data,
  input logic [STREAMS-1:0]          smp_en,
  input logic [STREAMS-1:0]          smp_vld,
  input logic [STREAMS*SAMPLE_W-1:0] word_data,
  input logic                        word_vld
);
  logic sup;
  logic full_beat;
  assign sup       = ($countones(smp_en) == 1) || ($countones(smp_en) == 2) ||
                     ($countones(smp_en) == STREAMS);
  assign full_beat = sup && ((smp_vld & smp_en) == smp_en);

  always @(posedge clk) begin
    if (!rst_n) p_reset_quiet_r1: assert (!word_vld && word_data == '0);
  end

  p_word_needs_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !full_beat |=> !word_vld);

  p_hold_between_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld |-> $stable(word_data));

  p_quad_direct_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (full_beat && smp_en == '1) |=> (word_vld && word_data == $past(smp_data)));

  p_unsup_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sup |=> !word_vld);

  p_single_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && $countones(smp_en) == 1) |=> !word_vld);
endmodule

bind iqp_packer iqp_packer_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_data  (smp_data),
  .smp_en    (smp_en),
  .smp_vld   (smp_vld),
  .word_data (word_data),
  .word_vld  (word_vld)
);

// File: tb/tb_iqp_packer.sv
`timescale 1ns/1ps
module tb_iqp_packer;
  localparam int WD_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] smp_data = '0;
  logic [3:0]  smp_en = '0;
  logic [3:0]  smp_vld = '0;
  logic [63:0] word_data;
  logic        word_vld;
  int          n_tests = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  iqp_packer dut (
    .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_en(smp_en),
    .smp_vld(smp_vld), .word_data(word_data), .word_vld(word_vld)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one cycle, then check the registered result of that cycle.
  task automatic step(input logic [3:0] en, input logic [3:0] vld, input logic [63:0] d,
                      input bit ev, input logic [63:0] ed, input string tag);
    @(negedge clk);
    smp_en = en; smp_vld = vld; smp_data = d;
    @(posedge clk);
    #1;
    chk({tag, " vld"}, {63'd0, word_vld}, {63'd0, ev});
    if (ev) chk({tag, " data"}, word_data, ed);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 vld in reset", {63'd0, word_vld}, 64'd0);
    chk("R1 data in reset", word_data, 64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 vld after release", {63'd0, word_vld}, 64'd0);
  endtask

  task automatic t_single;
    // stream 0 only; other streams valid with junk data (R9)
    step(4'b0001, 4'hF, 64'hBAD3_BAD2_BAD1_1000, 0, 0, "R3 s0 b0");
    step(4'b0001, 4'hF, 64'hBAD3_BAD2_BAD1_1001, 0, 0, "R3 s0 b1");
    step(4'b0001, 4'hF, 64'hBAD3_BAD2_BAD1_1002, 0, 0, "R3 s0 b2");
    step(4'b0001, 4'hF, 64'hBAD3_BAD2_BAD1_1003, 1, 64'h1003_1002_1001_1000, "R3 R9 s0 word");
    // stream 3 only
    step(4'b1000, 4'b1000, 64'h3000_0000_0000_0000, 0, 0, "R3 s3 b0");
    step(4'b1000, 4'b1000, 64'h3001_0000_0000_0000, 0, 0, "R3 s3 b1");
    step(4'b1000, 4'b1000, 64'h3002_0000_0000_0000, 0, 0, "R3 s3 b2");
    step(4'b1000, 4'b1000, 64'h3003_0000_0000_0000, 1, 64'h3003_3002_3001_3000, "R3 s3 word");
    step(4'b1000, 4'b0000, 64'h0, 0, 0, "R6 idle after word");
    chk("R6 data held", word_data, 64'h3003_3002_3001_3000);
  endtask

  task automatic t_pair;
    step(4'b0011, 4'b0011, 64'h0000_0000_A0B1_A0A1, 0, 0, "R4 ch0 b0");
    step(4'b0011, 4'b0011, 64'h0000_0000_A1B1_A1A1, 1, 64'hA1B1_A1A1_A0B1_A0A1, "R4 ch0 word");
    step(4'b1100, 4'b1100, 64'hC0B1_C0A1_0000_0000, 0, 0, "R4 ch1 b0");
    step(4'b1100, 4'b1100, 64'hC1B1_C1A1_0000_0000, 1, 64'hC1B1_C1A1_C0B1_C0A1, "R4 ch1 word");
    step(4'b0101, 4'b0101, 64'h0000_E0C0_0000_E0A0, 0, 0, "R4 I0I1 b0");
    step(4'b0101, 4'b1111, 64'hFFFF_E1C0_FFFF_E1A0, 1, 64'hE1C0_E1A0_E0C0_E0A0, "R4 R9 I0I1 word");
  endtask

  task automatic t_quad;
    step(4'hF, 4'hF, 64'h4444_3333_2222_1111, 1, 64'h4444_3333_2222_1111, "R5 quad 0");
    step(4'hF, 4'hF, 64'h8888_7777_6666_5555, 1, 64'h8888_7777_6666_5555, "R5 R6 quad back2back");
    step(4'hF, 4'h7, 64'h0, 0, 0, "R2 quad partial valid");
    chk("R6 hold after quad", word_data, 64'h8888_7777_6666_5555);
  endtask

  task automatic t_stall;
    step(4'b0001, 4'b0001, 64'h0000_0000_0000_5A00, 0, 0, "R2 b0");
    step(4'b0001, 4'b0000, 64'h0000_0000_0000_DEAD, 0, 0, "R2 stall");
    step(4'b0001, 4'b0001, 64'h0000_0000_0000_5A01, 0, 0, "R2 b1");
    step(4'b0001, 4'b1110, 64'h0000_0000_0000_BEEF, 0, 0, "R2 R9 stall other vld");
    step(4'b0001, 4'b0001, 64'h0000_0000_0000_5A02, 0, 0, "R2 b2");
    step(4'b0001, 4'b0001, 64'h0000_0000_0000_5A03, 1, 64'h5A03_5A02_5A01_5A00, "R2 word");
    step(4'b0011, 4'b0001, 64'h0000_0000_7777_7777, 0, 0, "R2 pair half valid");
  endtask

  task automatic t_change;
    step(4'b0001, 4'b0001, 64'h0000_0000_0000_00A0, 0, 0, "R7 single b0");
    step(4'b0001, 4'b0001, 64'h0000_0000_0000_00A1, 0, 0, "R7 single b1");
    step(4'b0011, 4'b0011, 64'h0000_0000_00C1_00C0, 0, 0, "R7 switch beat");
    step(4'b0011, 4'b0011, 64'h0000_0000_00D1_00D0, 1, 64'h00D1_00D0_00C1_00C0, "R7 fresh word");
    step(4'b0001, 4'b0001, 64'h0000_0000_0000_0B00, 0, 0, "R7 single again b0");
    step(4'b0010, 4'b0010, 64'h0000_0000_0C00_0000, 0, 0, "R7 other single b0");
    step(4'b0010, 4'b0010, 64'h0000_0000_0C01_0000, 0, 0, "R7 other single b1");
    step(4'b0010, 4'b0010, 64'h0000_0000_0C02_0000, 0, 0, "R7 other single b2");
    step(4'b0010, 4'b0010, 64'h0000_0000_0C03_0000, 1, 64'h0C03_0C02_0C01_0C00, "R7 other single word");
  endtask

  task automatic t_unsup;
    for (int i = 0; i < 4; i++)
      step(4'b0111, 4'hF, 64'h1234_5678_9ABC_DEF0, 0, 0, "R8 three streams");
    for (int i = 0; i < 4; i++)
      step(4'b0000, 4'hF, 64'h1234_5678_9ABC_DEF0, 0, 0, "R8 no streams");
    chk("R8 data untouched", word_data, 64'h0C03_0C02_0C01_0C00);
    step(4'b0011, 4'b0011, 64'h0000_0000_0002_0001, 0, 0, "R8 pair after unsup b0");
    step(4'b0011, 4'b0011, 64'h0000_0000_0004_0003, 1, 64'h0004_0003_0002_0001, "R8 pair after unsup word");
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(WD_CYCLES * 4);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    t_reset();
    t_single();
    t_pair();
    t_quad();
    t_stall();
    t_change();
    t_unsup();
    done = 1'b1;
    finish_run();
  end
endmodule